// File: doc/BRIEF.md
# Gated-Clock Serial Link Transmitter

This block moves bytes from a local valid/ready byte stream onto a short synchronous link between two chips. The link has an enable line, a forwarded clock and a data bus that is one or two bits wide. The forwarded clock runs only while a byte is on the wire. The block starts a byte only when the far-end receiver reports that it can take one.

The transmitter holds one byte in a shift register. A byte is accepted in the same clock edge that starts its transfer. During the transfer the forwarded clock runs at half the system clock rate. The data bus moves on each rising edge of that clock, so the receiver can sample on the falling edge. After the last beat the enable line drops for at least one system cycle. Only then is the receiver's ready line looked at again.

Top module: `lnk_ser_tx`

## Requirements
- R1: While `rst_n` is low, `tx_en`, `tx_clk` and `tx_dat` are all zero.
- R2: A byte is accepted on a rising system clock edge where `in_vld` and `in_rdy` are both high, and `in_rdy` is high only when the block is idle and `rx_rdy` is high. The same edge raises `tx_en` and puts the first beat on `tx_dat`.
- R3: `in_rdy` stays low for every cycle in which `tx_en` is high and for the gap cycle that follows.
- R4: `tx_clk` is low whenever `tx_en` is low.
- R5: In the first cycle of `tx_en`, `tx_clk` is high. While `tx_en` stays high, `tx_clk` changes level every system cycle.
- R6: While `tx_en` is high, `tx_dat` changes only in a cycle where `tx_clk` has just gone from low to high.
- R7: Bits go out most significant first. Beat k (counting from 0) carries byte bits [7-k*LANES : 8-(k+1)*LANES]. When LANES is 2, the higher bit of each pair is on `tx_dat[1]`.
- R8: For each byte, `tx_en` stays high for exactly 2*8/LANES system cycles: 16 cycles when LANES is 1 and 8 cycles when LANES is 2.
- R9: After each byte, `tx_en` is low for at least one cycle. If `rx_rdy` is low after that gap, no new byte starts, even when `in_vld` is high.
- R10: `tx_dat` is zero whenever `tx_en` is low.
- R11: LANES may be 1 or 2, which gives 8 or 4 rising edges of `tx_clk` per byte. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A byte is offered on `in_dat` |
| in_rdy | output | 1 | The block will take the offered byte on this edge |
| in_dat | input | BYTE_W | Byte to send |
| rx_rdy | input | 1 | The far-end receiver can take a byte |
| tx_en | output | 1 | A byte transfer is in progress on the link |
| tx_clk | output | 1 | Forwarded link clock, runs only while `tx_en` is high |
| tx_dat | output | LANES | Link data, updated on the rising edge of `tx_clk` |

## Verification
All link outputs come straight from registers. The first beat and `tx_en` appear right after the handshake edge. The last beat stays until 2*8/LANES cycles later, then `tx_en` drops for the gap cycle, and `in_rdy` can return one cycle after that. The bench drives inputs and samples outputs on the falling system edge, so every sample shows the settled state of one system cycle. A monitor rebuilds each byte from the cycles in which `tx_clk` is high and compares it with the queue the driver filled. The monitor also measures the width of the enable pulse and the low run between pulses against those cycle counts. Hold-off cases keep `rx_rdy` low for a fixed number of sampled cycles and confirm that nothing starts before it rises.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } lnk_st_e;

   function automatic int unsigned beats_per_byte(input int unsigned bw, input int unsigned lanes);
      return bw / lanes;
   endfunction

endpackage

// File: rtl/lnk_tx_ctrl.sv
module lnk_tx_ctrl
   import lnk_tx_pkg::*;
#(
   parameter int unsigned BEATS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic rx_rdy,
   output logic in_rdy,
   output logic load,
   output logic shift,
   output logic clr,
   output logic link_en,
   output logic link_clk
);

   localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int unsigned RW = $clog2(2 * BEATS + 1);
   localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);
   localparam logic [RW-1:0] EN_CYCLES = RW'(2 * BEATS);

   lnk_st_e        state_q;
   logic [CW-1:0]  cnt_q;
   logic           ph_q;
   logic           last;

   assign last     = (cnt_q == LAST_BEAT);
   assign in_rdy   = (state_q == ST_IDLE) && rx_rdy;
   assign load     = in_rdy && in_vld;
   assign shift    = (state_q == ST_SEND) && !ph_q && !last;
   assign clr      = (state_q == ST_SEND) && !ph_q && last;
   assign link_en  = (state_q == ST_SEND);
   assign link_clk = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ph_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (load) begin
                  state_q <= ST_SEND;
                  ph_q    <= 1'b1;
                  cnt_q   <= '0;
               end
            end
            ST_SEND: begin
               if (ph_q) begin
                  ph_q <= 1'b0;
               end else if (last) begin
                  state_q <= ST_GAP;
               end else begin
                  ph_q  <= 1'b1;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_GAP:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Enable pulse width monitor for the R8 check
   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (link_en) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   a_r2_start_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> $past(in_vld && rx_rdy));
   a_r3_rdy_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_rdy |-> !link_en);
   a_r4_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |-> !link_clk);
   a_r5_first_phase_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> link_clk);
   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && $past(link_en)) |-> (link_clk != $past(link_clk)));
   a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_en) |-> (run_q == EN_CYCLES));
   a_r9_gap_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_en) |=> !link_en);

endmodule

// File: rtl/lnk_tx_shreg.sv
module lnk_tx_shreg #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              clr,
   input  logic [BYTE_W-1:0] din,
   input  logic              link_en,
   input  logic              link_clk,
   output logic [LANES-1:0]  dat
);

   logic [BYTE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (load)  sh_q <= din;
      else if (clr)   sh_q <= '0;
      else if (shift) sh_q <= sh_q << LANES;
   end

   generate
      if (LANES == 1) begin : g_serial
         assign dat = sh_q[BYTE_W-1];
      end else begin : g_wide
         assign dat = sh_q[BYTE_W-1 -: LANES];
      end
   endgenerate

   a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |-> (dat == '0));
   a_r6_move_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && $past(link_en) && (dat != $past(dat))) |-> (link_clk && !$past(link_clk)));

endmodule

// File: rtl/lnk_ser_tx.sv
module lnk_ser_tx
   import lnk_tx_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   output logic              in_rdy,
   input  logic [BYTE_W-1:0] in_dat,
   input  logic              rx_rdy,
   output logic              tx_en,
   output logic              tx_clk,
   output logic [LANES-1:0]  tx_dat
);

   localparam int unsigned BEATS = beats_per_byte(BYTE_W, LANES);

   generate
      if (LANES != 1 && LANES != 2) begin : g_bad_lanes
         $error("lnk_ser_tx: LANES must be 1 or 2");
      end
      if ((BYTE_W % LANES) != 0) begin : g_bad_width
         $error("lnk_ser_tx: BYTE_W must be a multiple of LANES");
      end
   endgenerate

   logic load, shift, clr;

   lnk_tx_ctrl #(.BEATS(BEATS)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .rx_rdy   (rx_rdy),
      .in_rdy   (in_rdy),
      .load     (load),
      .shift    (shift),
      .clr      (clr),
      .link_en  (tx_en),
      .link_clk (tx_clk)
   );

   lnk_tx_shreg #(.BYTE_W(BYTE_W), .LANES(LANES)) shreg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .shift    (shift),
      .clr      (clr),
      .din      (in_dat),
      .link_en  (tx_en),
      .link_clk (tx_clk),
      .dat      (tx_dat)
   );

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!tx_en && !tx_clk && (tx_dat == '0)));

endmodule

// File: tb/lnk_ser_tx_tb.sv
`timescale 1ns/1ps
module lnk_ser_tx_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // DUT A: one lane
   logic       a_vld = 1'b0, a_rdy, a_rxr = 1'b0, a_en, a_clk;
   logic [7:0] a_dat = 8'h00;
   logic [0:0] a_tx;
   // DUT B: two lanes
   logic       b_vld = 1'b0, b_rdy, b_rxr = 1'b0, b_en, b_clk;
   logic [7:0] b_dat = 8'h00;
   logic [1:0] b_tx;

   lnk_ser_tx #(.BYTE_W(8), .LANES(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(a_vld), .in_rdy(a_rdy), .in_dat(a_dat),
      .rx_rdy(a_rxr), .tx_en(a_en), .tx_clk(a_clk), .tx_dat(a_tx));

   lnk_ser_tx #(.BYTE_W(8), .LANES(2)) dut_w2_i (
      .clk(clk), .rst_n(rst_n), .in_vld(b_vld), .in_rdy(b_rdy), .in_dat(b_dat),
      .rx_rdy(b_rxr), .tx_en(b_en), .tx_clk(b_clk), .tx_dat(b_tx));

   logic [7:0] qa[$];
   logic [7:0] qb[$];

   // ---------------- monitor A ----------------
   logic pa_en = 0, pa_clk = 0;
   logic [0:0] pa_tx = 0;
   logic [15:0] acc_a;
   int beats_a, hi_a, low_a, frames_a = 0;
   int va3 = 0, va4 = 0, va5 = 0, va6 = 0, va10 = 0;
   always @(negedge clk) if (rst_n) begin
      if (a_en) begin
         if (!pa_en) begin
            if (frames_a > 0) chk(low_a >= 1, "R9", "A gap cycles", low_a, 1);
            acc_a = 0; beats_a = 0; hi_a = 0;
            if (!a_clk) va5++;
         end else if (a_clk == pa_clk) va5++;
         if (pa_en && a_tx != pa_tx && !(a_clk && !pa_clk)) va6++;
         if (a_rdy) va3++;
         hi_a++;
         if (a_clk) begin acc_a = (acc_a << 1) | 16'(a_tx); beats_a++; end
      end else begin
         if (a_clk) va4++;
         if (a_tx != 0) va10++;
         if (pa_en) begin
            if (a_rdy) va3++; // gap cycle
            if (qa.size() == 0) chk(1'b0, "R2", "A unexpected byte", acc_a, 0);
            else begin
               logic [7:0] e;
               e = qa.pop_front();
               chk(acc_a[7:0] == e, "R7", "A byte", acc_a, e);
               chk(hi_a == 16, "R8", "A en cycles", hi_a, 16);
               chk(beats_a == 8, "R11", "A beats", beats_a, 8);
            end
            frames_a++;
            low_a = 0;
         end
         low_a++;
      end
      pa_en = a_en; pa_clk = a_clk; pa_tx = a_tx;
   end

   // ---------------- monitor B ----------------
   logic pb_en = 0, pb_clk = 0;
   logic [1:0] pb_tx = 0;
   logic [15:0] acc_b;
   int beats_b, hi_b, low_b, frames_b = 0;
   int vb3 = 0, vb4 = 0, vb5 = 0, vb6 = 0, vb10 = 0;
   always @(negedge clk) if (rst_n) begin
      if (b_en) begin
         if (!pb_en) begin
            if (frames_b > 0) chk(low_b >= 1, "R9", "B gap cycles", low_b, 1);
            acc_b = 0; beats_b = 0; hi_b = 0;
            if (!b_clk) vb5++;
         end else if (b_clk == pb_clk) vb5++;
         if (pb_en && b_tx != pb_tx && !(b_clk && !pb_clk)) vb6++;
         if (b_rdy) vb3++;
         hi_b++;
         if (b_clk) begin acc_b = (acc_b << 2) | 16'(b_tx); beats_b++; end
      end else begin
         if (b_clk) vb4++;
         if (b_tx != 0) vb10++;
         if (pb_en) begin
            if (b_rdy) vb3++;
            if (qb.size() == 0) chk(1'b0, "R2", "B unexpected byte", acc_b, 0);
            else begin
               logic [7:0] e;
               e = qb.pop_front();
               chk(acc_b[7:0] == e, "R7", "B byte", acc_b, e);
               chk(hi_b == 8, "R8", "B en cycles", hi_b, 8);
               chk(beats_b == 4, "R11", "B beats", beats_b, 4);
            end
            frames_b++;
            low_b = 0;
         end
         low_b++;
      end
      pb_en = b_en; pb_clk = b_clk; pb_tx = b_tx;
   end

   // ---------------- drivers ----------------
   task automatic send_a(input logic [7:0] v);
      @(negedge clk);
      a_vld = 1'b1; a_dat = v;
      #0.1;
      while (!a_rdy) begin @(negedge clk); #0.1; end
      qa.push_back(v);
      @(negedge clk);
      a_vld = 1'b0;
   endtask

   task automatic send_b(input logic [7:0] v);
      @(negedge clk);
      b_vld = 1'b1; b_dat = v;
      #0.1;
      while (!b_rdy) begin @(negedge clk); #0.1; end
      qb.push_back(v);
      @(negedge clk);
      b_vld = 1'b0;
   endtask

   bit done = 0;

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "WDOG", "watchdog expired", 0, 1);
         summary();
      end
   end

   localparam logic [7:0] PAT [8] = '{8'hA5, 8'h3C, 8'h80, 8'h01, 8'hFF, 8'h00, 8'h96, 8'h7E};

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!a_en && !a_clk && a_tx == 0, "R1", "A outputs in reset", {a_en, a_clk, a_tx}, 0);
      chk(!b_en && !b_clk && b_tx == 0, "R1", "B outputs in reset", {b_en, b_clk, b_tx}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      a_rxr = 1'b1; b_rxr = 1'b1;
      @(negedge clk);
      chk(a_rdy, "R2", "A in_rdy idle with rx_rdy", a_rdy, 1);

      // main patterns, back to back
      for (int i = 0; i < 8; i++) send_a(PAT[i]);
      for (int i = 0; i < 8; i++) send_b(PAT[i]);

      // R2: hold off while receiver not ready
      @(negedge clk);
      while (a_en) @(negedge clk);
      a_rxr = 1'b0; a_vld = 1'b1; a_dat = 8'h5A;
      begin
         int bad = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (a_en || a_rdy) bad++;
         end
         chk(bad == 0, "R2", "A no start without rx_rdy", bad, 0);
      end
      a_rxr = 1'b1;
      #0.1;
      chk(a_rdy, "R2", "A in_rdy follows rx_rdy", a_rdy, 1);
      qa.push_back(8'h5A);
      @(negedge clk);
      a_vld = 1'b0;
      chk(a_en && a_clk && a_tx == 1'b0, "R2", "A starts on handshake edge", {a_en, a_clk, a_tx}, 3'b110);

      // R9: receiver drops during gap, pending byte must wait
      while (a_en) @(negedge clk);
      a_rxr = 1'b0; a_vld = 1'b1; a_dat = 8'hC3;
      begin
         int bad = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (a_en) bad++;
         end
         chk(bad == 0, "R9", "A held after gap", bad, 0);
      end
      a_rxr = 1'b1;
      #0.1;
      while (!a_rdy) begin @(negedge clk); #0.1; end
      qa.push_back(8'hC3);
      @(negedge clk);
      a_vld = 1'b0;

      // R9 on B as well
      while (b_en) @(negedge clk);
      b_rxr = 1'b0; b_vld = 1'b1; b_dat = 8'h2D;
      begin
         int bad = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (b_en || b_rdy) bad++;
         end
         chk(bad == 0, "R9", "B held after gap", bad, 0);
      end
      b_rxr = 1'b1;
      #0.1;
      while (!b_rdy) begin @(negedge clk); #0.1; end
      qb.push_back(8'h2D);
      @(negedge clk);
      b_vld = 1'b0;

      repeat (40) @(negedge clk);
      chk(qa.size() == 0, "R7", "A queue drained", qa.size(), 0);
      chk(qb.size() == 0, "R7", "B queue drained", qb.size(), 0);
      chk(va3 + vb3 == 0, "R3", "in_rdy high while busy", va3 + vb3, 0);
      chk(va4 + vb4 == 0, "R4", "tx_clk high while tx_en low", va4 + vb4, 0);
      chk(va5 + vb5 == 0, "R5", "tx_clk phase or toggle errors", va5 + vb5, 0);
      chk(va6 + vb6 == 0, "R6", "tx_dat moved off rising tx_clk", va6 + vb6, 0);
      chk(va10 + vb10 == 0, "R10", "tx_dat nonzero while idle", va10 + vb10, 0);
      chk(frames_a == 10, "R8", "A frame count", frames_a, 10);
      chk(frames_b == 9, "R11", "B frame count", frames_b, 9);
      done = 1;
      summary();
   end

endmodule